// File: doc/BRIEF.md
# Sector Hamming ECC Engine

This block builds a 24-bit single-error-correcting parity code over a sector of bytes while the bytes stream past. Each byte is placed by its position in the sector (byte index and bit index). The block keeps two parity halves. The upper half collects the positions of every set bit, and the lower half collects the complements of those positions. The packed code is presented inverted, so a fully erased sector (all bytes 0xFF) produces a code of all ones and matches erased spare storage.

Several independent parity contexts exist, one per chip-select. An incoming byte is routed to one of them, and a per-context start bit restarts that context. Taking the code through the read strobe, or launching a check, presents the selected context and clears it.

A check compares a stored code with the freshly computed code of the selected context and classifies the difference. On a single data-bit error the engine reads the affected byte from an external sector buffer and writes it back with that bit flipped.

Top module: `sector_hamming_ecc`

## Requirements
- R1: After reset every context is empty, so code_o reads all ones. chk_done, chk_busy, buf_rd and buf_wr are low.
- R2: For each set bit of the byte at sector index a, bit b, let position p = {a, b[2:0]} (12 bits by default). The upper half is the XOR of all such p, and the lower half is the XOR of all ~p. code_o = ~{upper, lower}: the upper half sits in bits 23:12, and bits 7:0 are the first code byte.
- R3: An erased sector (every byte 0xFF) yields code_o = 0xFFFFFF, and a check against a stored 0xFFFFFF reports clean.
- R4: start[i] clears context i. A byte for context i in the same cycle is taken as byte index 0 of the new sector. Other contexts are unaffected.
- R5: rd_take presents the selected context's code in that cycle and clears the context. A byte for that context in the same cycle becomes byte index 0 of the next sector.
- R6: Status codes are 0 clean, 1 data bit fixed, 2 error in the code only, 3 uncorrectable. A zero difference between the stored and computed codes gives status 0 with no buffer access.
- R7: If the low 12 bits of (diff >> 12) XOR diff are all ones, the error is in one data bit, at byte diff >> 15 and bit (diff >> 12) & 7. If that byte index is below SECTOR_BYTES, the engine issues one buffer read and then one write of that byte with the bit flipped, and reports status 1.
- R8: A single-data-bit difference whose byte index is not below SECTOR_BYTES reports status 3 with no buffer access.
- R9: A difference with exactly one bit set reports status 2 with no buffer access.
- R10: Any other nonzero difference reports status 3 with no buffer access.
- R11: An accepted chk_start clears the selected context in the same way as rd_take. A chk_start while chk_busy is high is ignored: no clear, no second result.
- R12: Bytes update only the context named by in_cs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte present on in_byte |
| in_cs | input | CS_W | Context receiving the byte |
| in_byte | input | 8 | Data byte |
| start | input | NUM_CS | Per-context restart bits |
| rd_cs | input | CS_W | Context shown on code_o and used by a check |
| rd_take | input | 1 | Take the code and clear the context |
| code_o | output | CODE_W | Inverted packed code of context rd_cs |
| chk_start | input | 1 | Launch a compare and correct |
| stored_code | input | CODE_W | Code read back from storage |
| chk_busy | output | 1 | Check in progress |
| chk_done | output | 1 | One-cycle result pulse |
| chk_status | output | 2 | Result class (R6) |
| buf_addr | output | ADDR_W | Sector buffer byte index |
| buf_rd | output | 1 | Buffer read request, data due next cycle |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Corrected byte |

## Verification
A restart or a code take can land in the same cycle as a byte for the same context. The block must then clear the old sector and still count that byte as index 0 of the new one. The bench drives the start bit, and separately rd_take, together with a data byte. It first checks that code_o in that cycle still shows the old sector. It then checks that the following code equals the reference code of a sector beginning with that byte. A second chk_start raised while a correction is in flight must neither clear its context nor produce an extra result pulse. The scoreboard treats any unexpected pulse as a failure.

// File: rtl/hecc_pkg.sv
package hecc_pkg;

    typedef enum logic [1:0] {
        ST_CLEAN     = 2'd0,
        ST_FIXED     = 2'd1,
        ST_CODE_ONLY = 2'd2,
        ST_FATAL     = 2'd3
    } ecc_status_e;

    typedef enum logic [1:0] {
        FX_IDLE  = 2'd0,
        FX_EVAL  = 2'd1,
        FX_READ  = 2'd2,
        FX_WRITE = 2'd3
    } fix_state_e;

endpackage

// File: rtl/hecc_accum.sv
module hecc_accum #(
    parameter int ADDR_W = 9,
    parameter int HALF_W = ADDR_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              byte_en,
    input  logic [7:0]        byte_in,
    output logic [HALF_W-1:0] par_hi,
    output logic [HALF_W-1:0] par_lo
);

    typedef struct packed {
        logic [HALF_W-1:0] hi;
        logic [HALF_W-1:0] lo;
        logic [ADDR_W-1:0] cnt;
    } acc_t;

    acc_t acc_d, acc_q;
    logic [ADDR_W-1:0] idx;

    always_comb begin
        acc_d = acc_q;
        idx   = acc_q.cnt;
        if (clear) begin
            acc_d.hi  = '0;
            acc_d.lo  = '0;
            acc_d.cnt = '0;
            idx       = '0;
        end
        if (byte_en) begin
            for (int b = 0; b < 8; b++) begin
                if (byte_in[b]) begin
                    acc_d.hi = acc_d.hi ^ {idx, 3'(b)};
                    acc_d.lo = acc_d.lo ^ ~{idx, 3'(b)};
                end
            end
            acc_d.cnt = idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign par_hi = acc_q.hi;
    assign par_lo = acc_q.lo;

    // R4
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear && !byte_en) |=> (acc_q.hi == '0 && acc_q.lo == '0 && acc_q.cnt == '0));

    // R12
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !byte_en) |=> $stable(acc_q));

endmodule

// File: rtl/hecc_fix.sv
module hecc_fix
    import hecc_pkg::*;
#(
    parameter int SECTOR_BYTES = 512,
    parameter int ADDR_W       = 9,
    parameter int HALF_W       = ADDR_W + 3,
    parameter int CODE_W       = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [CODE_W-1:0] calc_code,
    input  logic [CODE_W-1:0] stored_code,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata
);

    localparam logic [ADDR_W:0] LIMIT = (ADDR_W + 1)'(SECTOR_BYTES);

    typedef struct packed {
        fix_state_e        st;
        logic [CODE_W-1:0] diff;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        mask;
        ecc_status_e       res;
        logic              done;
    } fix_t;

    fix_t fx_d, fx_q;
    logic [HALF_W-1:0] d_hi, d_lo;
    logic              pair_ok;
    logic [ADDR_W-1:0] d_idx;

    assign d_hi    = fx_q.diff[CODE_W-1:HALF_W];
    assign d_lo    = fx_q.diff[HALF_W-1:0];
    assign pair_ok = ((d_hi ^ d_lo) == '1);
    assign d_idx   = d_hi[HALF_W-1:3];

    always_comb begin
        fx_d      = fx_q;
        fx_d.done = 1'b0;
        buf_rd    = 1'b0;
        buf_wr    = 1'b0;
        buf_wdata = buf_rdata ^ fx_q.mask;
        unique case (fx_q.st)
            FX_IDLE: begin
                if (go) begin
                    fx_d.diff = calc_code ^ stored_code;
                    fx_d.st   = FX_EVAL;
                end
            end
            FX_EVAL: begin
                fx_d.st = FX_IDLE;
                if (fx_q.diff == '0) begin
                    fx_d.res  = ST_CLEAN;
                    fx_d.done = 1'b1;
                end else if (pair_ok) begin
                    if ({1'b0, d_idx} < LIMIT) begin
                        fx_d.addr = d_idx;
                        fx_d.mask = 8'(1) << d_hi[2:0];
                        fx_d.st   = FX_READ;
                    end else begin
                        fx_d.res  = ST_FATAL;
                        fx_d.done = 1'b1;
                    end
                end else if ($countones(fx_q.diff) == 1) begin
                    fx_d.res  = ST_CODE_ONLY;
                    fx_d.done = 1'b1;
                end else begin
                    fx_d.res  = ST_FATAL;
                    fx_d.done = 1'b1;
                end
            end
            FX_READ: begin
                buf_rd  = 1'b1;
                fx_d.st = FX_WRITE;
            end
            FX_WRITE: begin
                buf_wr    = 1'b1;
                fx_d.res  = ST_FIXED;
                fx_d.done = 1'b1;
                fx_d.st   = FX_IDLE;
            end
            default: fx_d.st = FX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fx_q      <= '0;
            fx_q.st   <= FX_IDLE;
            fx_q.res  <= ST_CLEAN;
        end else begin
            fx_q <= fx_d;
        end
    end

    assign busy     = (fx_q.st != FX_IDLE);
    assign done     = fx_q.done;
    assign status   = fx_q.res;
    assign buf_addr = fx_q.addr;

    // R7
    wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(buf_rd));

    // R7
    fixed_follows_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == ST_FIXED) |-> $past(buf_wr));

    // R9
    no_touch_unless_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status != ST_FIXED) |-> (!$past(buf_wr) && !$past(buf_rd)));

    // R11
    single_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/sector_hamming_ecc.sv
module sector_hamming_ecc #(
    parameter int SECTOR_BYTES = 512,
    parameter int NUM_CS       = 4,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int ADDR_W = $clog2(SECTOR_BYTES),
    localparam int HALF_W = ADDR_W + 3,
    localparam int CODE_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CS_W-1:0]   in_cs,
    input  logic [7:0]        in_byte,
    input  logic [NUM_CS-1:0] start,
    input  logic [CS_W-1:0]   rd_cs,
    input  logic              rd_take,
    output logic [CODE_W-1:0] code_o,
    input  logic              chk_start,
    input  logic [CODE_W-1:0] stored_code,
    output logic              chk_busy,
    output logic              chk_done,
    output logic [1:0]        chk_status,
    output logic [ADDR_W-1:0] buf_addr,
    output logic              buf_rd,
    input  logic [7:0]        buf_rdata,
    output logic              buf_wr,
    output logic [7:0]        buf_wdata
);

    logic [HALF_W-1:0] hi_all [NUM_CS];
    logic [HALF_W-1:0] lo_all [NUM_CS];
    logic              take_now;
    logic              go;

    assign go       = chk_start && !chk_busy;
    assign take_now = rd_take || go;

    for (genvar i = 0; i < NUM_CS; i++) begin : g_ctx
        logic clr_i, en_i;
        assign clr_i = start[i] || (take_now && (rd_cs == CS_W'(i)));
        assign en_i  = in_valid && (in_cs == CS_W'(i));
        hecc_accum #(
            .ADDR_W (ADDR_W),
            .HALF_W (HALF_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (clr_i),
            .byte_en (en_i),
            .byte_in (in_byte),
            .par_hi  (hi_all[i]),
            .par_lo  (lo_all[i])
        );
    end

    assign code_o = ~{hi_all[rd_cs], lo_all[rd_cs]};

    hecc_fix #(
        .SECTOR_BYTES (SECTOR_BYTES),
        .ADDR_W       (ADDR_W),
        .HALF_W       (HALF_W),
        .CODE_W       (CODE_W)
    ) u_fix (
        .clk         (clk),
        .rst_n       (rst_n),
        .go          (go),
        .calc_code   (code_o),
        .stored_code (stored_code),
        .busy        (chk_busy),
        .done        (chk_done),
        .status      (chk_status),
        .buf_addr    (buf_addr),
        .buf_rd      (buf_rd),
        .buf_rdata   (buf_rdata),
        .buf_wr      (buf_wr),
        .buf_wdata   (buf_wdata)
    );

    // R11
    busy_persists_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_busy && !chk_done && buf_rd) |=> chk_busy);

endmodule

// File: tb/tb_sector_hamming_ecc.sv
`timescale 1ns/1ps
module tb_sector_hamming_ecc;

    localparam int SEC = 384;
    localparam int NCS = 4;

    typedef logic [7:0] sec_t [SEC];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_cs = '0;
    logic [7:0]  in_byte = '0;
    logic [3:0]  start = '0;
    logic [1:0]  rd_cs = '0;
    logic        rd_take = 1'b0;
    logic [23:0] code_o;
    logic        chk_start = 1'b0;
    logic [23:0] stored_code = '0;
    logic        chk_busy, chk_done;
    logic [1:0]  chk_status;
    logic [8:0]  buf_addr;
    logic        buf_rd, buf_wr;
    logic [7:0]  buf_rdata = '0;
    logic [7:0]  buf_wdata;

    int n_checks = 0;
    int n_err = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    logic [1:0] exp_q [$];
    logic [7:0] bufm [SEC];

    always #2.5 clk = ~clk;

    sector_hamming_ecc #(.SECTOR_BYTES(SEC), .NUM_CS(NCS)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_cs(in_cs),
        .in_byte(in_byte), .start(start), .rd_cs(rd_cs), .rd_take(rd_take),
        .code_o(code_o), .chk_start(chk_start), .stored_code(stored_code),
        .chk_busy(chk_busy), .chk_done(chk_done), .chk_status(chk_status),
        .buf_addr(buf_addr), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata)
    );

    always @(posedge clk) begin
        if (buf_rd) begin
            buf_rdata <= bufm[buf_addr];
            rd_cnt++;
        end
        if (buf_wr) begin
            bufm[buf_addr] <= buf_wdata;
            wr_cnt++;
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected status per result pulse
    always @(negedge clk) begin
        if (rst_n && chk_done) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                n_err++;
                $display("FAIL R11 actual=unexpected result %0d expected=none", chk_status);
            end else begin
                check("R6-status", {30'd0, chk_status}, {30'd0, exp_q.pop_front()});
            end
        end
    end

    function automatic logic [23:0] ref_code(sec_t d, int n);
        logic [11:0] hi = '0;
        logic [11:0] lo = '0;
        for (int a = 0; a < n; a++)
            for (int b = 0; b < 8; b++)
                if (d[a][b]) begin
                    hi ^= 12'((a << 3) | b);
                    lo ^= ~12'((a << 3) | b);
                end
        return ~{hi, lo};
    endfunction

    task automatic stream(int cs, sec_t d, int n, bit with_start);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_cs    = 2'(cs);
            in_byte  = d[i];
            start    = (with_start && i == 0) ? 4'(1 << cs) : 4'd0;
        end
        @(negedge clk);
        in_valid = 1'b0;
        start    = '0;
    endtask

    task automatic peek(int cs, string req, logic [23:0] exp);
        @(negedge clk);
        rd_cs = 2'(cs);
        #1 check(req, {8'd0, code_o}, {8'd0, exp});
    endtask

    task automatic run_check(int cs, logic [23:0] stored, logic [1:0] exp);
        @(negedge clk);
        rd_cs       = 2'(cs);
        stored_code = stored;
        chk_start   = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        chk_start = 1'b0;
        for (int k = 0; k < 20 && exp_q.size() != 0; k++) @(negedge clk);
        check("R6-drained", exp_q.size(), 0);
    endtask

    sec_t pat_a, pat_ff, pat_bad, pat_two, one_b;
    logic [23:0] ref_a;
    int wr0, rd0;

    initial begin
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < SEC; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            pat_a[i]  = s[23:16];
            pat_ff[i] = 8'hFF;
            one_b[i]  = 8'h00;
        end
        one_b[0] = 8'h5A;
        ref_a = ref_code(pat_a, SEC);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1-code", {8'd0, code_o}, 32'h00FF_FFFF);
        check("R1-flags", {28'd0, chk_done, chk_busy, buf_rd, buf_wr}, 32'd0);

        // R2 main code on a pseudo-random sector
        stream(0, pat_a, SEC, 1'b1);
        peek(0, "R2-code", ref_a);

        // R3 erased sector in context 1
        stream(1, pat_ff, SEC, 1'b1);
        peek(1, "R3-erased-code", 24'hFF_FFFF);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_check(1, 24'hFF_FFFF, 2'd0);
        check("R6-no-access", wr_cnt + rd_cnt, wr0 + rd0);
        // R11 accepted check clears the context
        peek(1, "R11-cleared", 24'hFF_FFFF);
        // R12 context 0 untouched by context 1 traffic
        peek(0, "R12-ctx0-kept", ref_a);

        // R7 single data bit error fixed in buffer
        pat_bad = pat_a;
        pat_bad[200][5] = ~pat_bad[200][5];
        bufm = pat_bad;
        stream(0, pat_bad, SEC, 1'b1);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_check(0, ref_a, 2'd1);
        check("R7-byte-restored", {24'd0, bufm[200]}, {24'd0, pat_a[200]});
        check("R7-one-read-one-write", (wr_cnt - wr0) * 16 + (rd_cnt - rd0), 17);

        // R9 error in the stored code only
        bufm = pat_a;
        stream(2, pat_a, SEC, 1'b1);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_check(2, ref_a ^ 24'h02_0000, 2'd2);
        check("R9-no-access", wr_cnt + rd_cnt, wr0 + rd0);

        // R10 two data bits wrong
        pat_two = pat_a;
        pat_two[10][0] = ~pat_two[10][0];
        pat_two[300][7] = ~pat_two[300][7];
        stream(3, pat_two, SEC, 1'b1);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_check(3, ref_a, 2'd3);
        check("R10-no-access", wr_cnt + rd_cnt, wr0 + rd0);

        // R8 correctable pattern pointing past the sector
        stream(0, pat_a, SEC, 1'b1);
        wr0 = wr_cnt; rd0 = rd_cnt;
        run_check(0, ref_a ^ {12'((400 << 3) | 2), ~12'((400 << 3) | 2)}, 2'd3);
        check("R8-no-access", wr_cnt + rd_cnt, wr0 + rd0);
        check("R8-buffer-intact", {24'd0, bufm[0]}, {24'd0, pat_a[0]});

        // R4 restart in the same cycle as the first byte, after stale bytes
        stream(2, pat_two, 10, 1'b0);
        stream(2, pat_a, SEC, 1'b1);
        peek(2, "R4-restart-same-cycle", ref_a);
        peek(0, "R4-other-ctx", 24'hFF_FFFF);

        // R5 take in the same cycle as a byte
        stream(3, pat_a, SEC, 1'b1);
        @(negedge clk);
        rd_cs = 2'd3; rd_take = 1'b1;
        in_valid = 1'b1; in_cs = 2'd3; in_byte = 8'h5A;
        #1 check("R5-value-before-clear", {8'd0, code_o}, {8'd0, ref_a});
        @(negedge clk);
        rd_take = 1'b0; in_valid = 1'b0;
        #1 check("R5-byte-is-index0", {8'd0, code_o}, {8'd0, ref_code(one_b, 1)});

        // R11 chk_start while busy is ignored
        bufm = pat_bad;
        stream(0, pat_bad, SEC, 1'b1);
        @(negedge clk);
        rd_cs = 2'd0; stored_code = ref_a; chk_start = 1'b1;
        exp_q.push_back(2'd1);
        @(negedge clk);
        rd_cs = 2'd2;
        @(negedge clk);
        chk_start = 1'b0;
        repeat (10) @(negedge clk);
        check("R11-single-result", exp_q.size(), 0);
        peek(2, "R11-busy-no-clear", ref_a);
        check("R11-fix-done", {24'd0, bufm[200]}, {24'd0, pat_a[200]});

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule